// File: doc/BRIEF.md
# Signed Integer Multiplier with Overflow Flag

This block multiplies two N-bit two's complement operands without any clock. It returns only the N least significant bits of the product, together with a flag. The flag is raised whenever the true product cannot be held in N signed bits. The full 2N-bit product is never formed. Instead, a truncated array produces just the low N+1 product bits.

An independent detector runs in parallel with that array. It inspects the operand bits alone to decide whether the combined count of significant bits makes overflow unavoidable. For the remaining borderline cases, the top two truncated product bits settle the answer.

The block is intended for a datapath that needs a same-width integer multiply with a trap or status flag. The result is available in the same cycle as the operands, with no handshake, and the surrounding pipeline registers it.

Top module: `tc_mul_ovf`

## Requirements
- R1: `prod_lo` equals bits N-1..0 of the exact signed product of `opa` and `opb` for every operand pair.
- R2: `ovf` is 1 exactly when the exact product is greater than 2^(N-1)-1 or less than -2^(N-1), and 0 otherwise.
- R3: When either operand is zero, `prod_lo` is all zeros and `ovf` is 0.
- R4: When both operands are -2^(N-1) (sign bit 1, all other bits 0), `ovf` is 1 and `prod_lo` is all zeros.
- R5: When one operand is -2^(N-1) and the other is -1 (all ones), `ovf` is 1 and `prod_lo` is the pattern with only bit N-1 set.
- R6: When `opb` is 1, `prod_lo` equals `opa` and `ovf` is 0 for every `opa`.
- R7: When `ovf` is 0 and both operands are nonzero, bit N-1 of `prod_lo` equals the XOR of the two operand sign bits (bit N-1).
- R8: Swapping `opa` and `opb` leaves both `prod_lo` and `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | Multiplicand, two's complement |
| opb | input | N | Multiplier, two's complement |
| prod_lo | output | N | Low N bits of the signed product |
| ovf | output | 1 | High when the product does not fit in N signed bits |

## Verification
All 65,536 operand pairs at N=8 are applied and compared with an arithmetic signed product. The operand pairs fall into three groups, and each group tests a different part of the design:
- Pairs with many significant bits exercise the early detector.
- Pairs whose significant-bit count is N-1 or N are decided only by the two top truncated bits.
- Small products must raise no flag at all.

The extreme operands -2^(N-1)×-2^(N-1) and -2^(N-1)×-1 are checked by name, as are the multiply-by-one and zero-operand patterns. A swapped-operand pass separates a detector that treats the two operands asymmetrically from a correct one.

// File: rtl/tc_mul_pkg.sv
package tc_mul_pkg;

  // Number of levels of a binary tree spanning w leaves (w >= 2).
  function automatic int ceil_log2(input int w);
    int r;
    r = 0;
    while ((1 << r) < w) r++;
    return r;
  endfunction

endpackage

// File: rtl/tc_mul_trunc.sv
// Truncated signed array: only product columns 0..N are built.
module tc_mul_trunc #(
  parameter int N = 8
) (
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [N:0]   prod
);
  localparam int PW = N + 1;

  logic [PW-1:0] mcand_sx;
  logic [PW-1:0] row [N];
  logic [PW-1:0] acc [N+1];

  assign mcand_sx = {mcand[N-1], mcand};
  assign acc[0]   = '0;

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [PW-1:0] shifted;
    assign shifted = mcand_sx << i;
    if (i == N - 1) begin : g_neg
      // the weight of the sign bit of the multiplier is negative
      assign row[i]  = mplier[i] ? (~shifted + 1'b1) : '0;
    end else begin : g_pos
      assign row[i]  = mplier[i] ? shifted : '0;
    end
    assign acc[i+1] = acc[i] + row[i];
  end

  assign prod = acc[N];

  logic signed [2*N-1:0] chk_full;
  assign chk_full = $signed(mcand) * $signed(mplier);

  always_comb begin
    p_trunc_bits_r1: assert (prod == chk_full[N:0]);
  end
endmodule

// File: rtl/ovf_suffix_or_bk.sv
// Prefix OR in Brent-Kung form: y[k] = x[0] | ... | x[k].
module ovf_suffix_or_bk #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int L = tc_mul_pkg::ceil_log2(W);
  localparam int M = 1 << L;
  localparam int S = 2 * L;

  logic [S-1:0][M-1:0] st;

  for (genvar j = 0; j < M; j++) begin : g_in
    if (j < W) begin : g_live
      assign st[0][j] = x[j];
    end else begin : g_pad
      assign st[0][j] = 1'b0;
    end
  end

  // up-sweep: node j at level d+1 combines blocks of 2^(d+1)
  for (genvar d = 0; d < L; d++) begin : g_up
    for (genvar j = 0; j < M; j++) begin : g_node
      if (((j + 1) % (1 << (d + 1))) == 0) begin : g_op
        assign st[d+1][j] = st[d][j] | st[d][j-(1<<d)];
      end else begin : g_wire
        assign st[d+1][j] = st[d][j];
      end
    end
  end

  // down-sweep: fill in the positions the up-sweep left partial
  for (genvar e = 0; e < L - 1; e++) begin : g_dn
    localparam int D = L - 2 - e;
    for (genvar j = 0; j < M; j++) begin : g_node
      if ((((j + 1) % (1 << (D + 1))) == (1 << D)) && (j >= (1 << (D + 1)))) begin : g_op
        assign st[L+e+1][j] = st[L+e][j] | st[L+e][j-(1<<D)];
      end else begin : g_wire
        assign st[L+e+1][j] = st[L+e][j];
      end
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_out
    assign y[k] = st[S-1][k];
  end

  always_comb begin
    p_prefix_total_r2: assert (y[W-1] == (|x));
    p_prefix_first_r2: assert (y[0] == x[0]);
    for (int k = 0; k < W - 1; k++) begin
      p_prefix_mono_r2: assert (!y[k] || y[k+1]);
    end
  end
endmodule

// File: rtl/ovf_prelim.sv
// Early overflow test from operand bits only.
module ovf_prelim #(
  parameter int N = 8
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic         early_ovf
);
  localparam int W = N - 2;

  logic [W-1:0] a_rel;   // a_rel[k]: bit N-2-k of opa differs from its sign
  logic [W-1:0] b_rel;   // b_rel[i-1]: bit i of opb differs from its sign
  logic [W-1:0] a_any;   // a_any[k]: some opa bit in N-2..N-2-k differs
  logic [W-1:0] term;

  for (genvar k = 0; k < W; k++) begin : g_rel
    assign a_rel[k] = opa[N-2-k] ^ opa[N-1];
    assign b_rel[k] = opb[k+1]   ^ opb[N-1];
  end

  ovf_suffix_or_bk #(.W(W)) u_scan (
    .x (a_rel),
    .y (a_any)
  );

  // multiplier bit i pairs with the OR of multiplicand bits N-2 down to N-1-i
  for (genvar i = 0; i < W; i++) begin : g_term
    assign term[i] = a_any[i] & b_rel[i];
  end

  assign early_ovf = |term;

  always_comb begin
    p_early_quiet_r2: assert (!((b_rel == '0) && early_ovf));
    p_early_quiet_a_r2: assert (!((a_rel == '0) && early_ovf));
  end
endmodule

// File: rtl/tc_mul_ovf.sv
module tc_mul_ovf #(
  parameter int N = 8
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic [N-1:0] prod_lo,
  output logic         ovf
);
  logic [N:0] prod_top;
  logic       early_ovf;
  logic       late_ovf;

  tc_mul_trunc #(.N(N)) u_array (
    .mcand  (opa),
    .mplier (opb),
    .prod   (prod_top)
  );

  ovf_prelim #(.N(N)) u_early (
    .opa       (opa),
    .opb       (opb),
    .early_ovf (early_ovf)
  );

  assign late_ovf = prod_top[N] ^ prod_top[N-1];
  assign prod_lo  = prod_top[N-1:0];
  assign ovf      = early_ovf | late_ovf;

  always_comb begin
    if ((opa == '0) || (opb == '0)) begin
      p_zero_operand_r3: assert (!ovf && (prod_lo == '0));
    end
    if (opb == N'(1)) begin
      p_times_one_r6: assert (!ovf && (prod_lo == opa));
    end
    if (!ovf && (opa != '0) && (opb != '0)) begin
      p_result_sign_r7: assert (prod_lo[N-1] == (opa[N-1] ^ opb[N-1]));
    end
  end
endmodule

// File: tb/tc_mul_ovf_bench.sv
module tc_mul_ovf_bench;
  localparam int N = 8;
  localparam int HI = (1 << (N - 1)) - 1;
  localparam int LO = -(1 << (N - 1));

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] opa = '0;
  logic [N-1:0] opb = '0;
  logic [N-1:0] prod_lo;
  logic         ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tc_mul_ovf #(.N(N)) u_tc_mul_ovf (
    .opa     (opa),
    .opb     (opb),
    .prod_lo (prod_lo),
    .ovf     (ovf)
  );

  task automatic apply(input int a, input int b);
    @(negedge clk);
    opa = N'(a);
    opb = N'(b);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [N-1:0] exp_p, input logic exp_v);
    checks++;
    if (prod_lo !== exp_p || ovf !== exp_v) begin
      fails++;
      $display("FAIL %s opa=%0d opb=%0d: got p=%h v=%b, expected p=%h v=%b",
               req, $signed(opa), $signed(opb), prod_lo, ovf, exp_p, exp_v);
    end
  endtask

  task automatic check_arith(input string req, input int a, input int b);
    int full;
    full = a * b;
    apply(a, b);
    check(req, N'(full), (full > HI) || (full < LO));
  endtask

  initial begin
    // reset-time state: both operands zero (R3)
    @(posedge clk);
    #1;
    check("R3 initial", '0, 1'b0);

    // R1 and R2: every operand pair against the arithmetic product
    for (int a = LO; a <= HI; a++) begin
      for (int b = LO; b <= HI; b++) begin
        check_arith("R1/R2 sweep", a, b);
      end
    end

    // R3: zero on either side
    apply(0, LO);  check("R3 zero left", '0, 1'b0);
    apply(HI, 0);  check("R3 zero right", '0, 1'b0);

    // R4: most negative squared
    apply(LO, LO); check("R4 min*min", '0, 1'b1);

    // R5: most negative times minus one, both orders
    apply(LO, -1); check("R5 min*-1", N'(LO), 1'b1);
    apply(-1, LO); check("R5 -1*min", N'(LO), 1'b1);

    // R6: multiply by one over all multiplicands
    for (int a = LO; a <= HI; a++) begin
      apply(a, 1);
      check("R6 times one", N'(a), 1'b0);
    end

    // R7: sign of an in-range product with nonzero operands
    apply(-11, 11); check("R7 mixed sign", N'(-121), 1'b0);
    apply(-8, -15); check("R7 both negative", N'(120), 1'b0);

    // R8: swapped operands give identical outputs
    for (int k = 0; k < 256; k++) begin
      int a;
      int b;
      logic [N-1:0] p1;
      logic         v1;
      a = ((k * 37) % 256) + LO;
      b = ((k * 91 + 13) % 256) + LO;
      apply(a, b);
      p1 = prod_lo;
      v1 = ovf;
      apply(b, a);
      check("R8 swap", p1, v1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule